// File: doc/BRIEF.md
# Time-of-Day Snapshot Register File

This block holds the byte-wide register image that a serial host sees in front of a live time/date counter. Eight field registers keep a frozen copy of the counter's eight time fields. A control byte selects the frequency-measurement output, two test modes and a time-set lock. A read-only flag byte reports which fields moved between two consecutive snapshots.

The host takes a snapshot with one command and then reads only the fields whose flags are set. To set the clock, it writes the desired fields into the snapshot registers, clears the lock and issues the load command. The block then presents a one-cycle load strobe with the snapshot contents to the counter. The counting itself happens outside the block. The block only drives the test-mode controls and gates a divider tap onto the measurement output.

Top module: `tod_snapshot_regs`

## Requirements
- R1: After reset, every readable byte reads 0x00, and `load_en`, `test_fast`, `test_parallel`, `lock` and `freq_out` are low.
- R2: A host write to address 0 or to addresses 2..9 stores the byte, and it reads back on `rdata` from the next cycle. In the control byte, bit 0 enables frequency measurement, bit 2 drives `test_fast`, bit 3 drives `test_parallel` and bit 4 is the time-set lock.
- R3: Host writes to address 1 and to addresses 10..15 are ignored. Addresses 10..15 always read 0x00.
- R4: Command code 0xF copies the live fields into addresses 2..9. Field k is `live_time[8k+7:8k]` and lands at address 2+k, in this order: seconds, minutes, hours, day of month, month, year, weekday, week number. The copy is readable in the cycle after the command.
- R5: On a 0xF command, flag bit k (address 1) becomes 1 if live field k differs from the value held at address 2+k before the command, and 0 otherwise.
- R6: Command code 0xE with the lock bit clear raises `load_en` for exactly one cycle, in the cycle after the command. While `load_en` is high, `load_time` carries addresses 2..9 packed as in R4. The command also clears address 1.
- R7: Command code 0xE with the lock bit set produces no `load_en` pulse and leaves address 1 unchanged.
- R8: `freq_out` equals `div_tap` while control bit 0 is set and `cs_n` is high, and is 0 otherwise.
- R9: Command codes other than 0xE and 0xF change no register and produce no `load_en`.
- R10: While `cmd_en` is high, a host write in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select, active low; gates the measurement output |
| wr_en | input | 1 | Host byte write strobe |
| addr | input | 4 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cmd_en | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (0xE load clock, 0xF snapshot) |
| live_time | input | 64 | Live counter fields, field k in bits 8k+7:8k |
| div_tap | input | 1 | 256 Hz square wave from the timekeeping divider |
| load_en | output | 1 | One-cycle strobe that loads the counter |
| load_time | output | 64 | Field values to load, packed as `live_time` |
| test_fast | output | 1 | Accelerated-timekeeping test control |
| test_parallel | output | 1 | Carry-free parallel-increment test control |
| lock | output | 1 | Time-set lock state |
| freq_out | output | 1 | Frequency-measurement output |

## Verification
Register writes and both commands act at the clock edge where they are presented. Stored bytes, snapshots and flags are therefore visible on `rdata` one time unit after that edge. `load_en` is high during the one cycle that follows an accepted load command and low again after the next edge. The bench drives inputs after a falling edge and checks one time unit after the next rising edge, so each sample falls inside the cycle the result is due. `freq_out` is combinational, so it is sampled a moment after its inputs settle, away from any clock edge.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_LOAD_CLOCK = 4'hE;
  localparam logic [CMD_W-1:0] CMD_SNAPSHOT   = 4'hF;

  localparam int CTL_FREQ  = 0;
  localparam int CTL_TEST0 = 2;
  localparam int CTL_TEST1 = 3;
  localparam int CTL_LOCK  = 4;

  function automatic logic field_moved(input logic [7:0] now_v, input logic [7:0] prev_v);
    return now_v != prev_v;
  endfunction
endpackage

// File: rtl/tsr_field_slice.sv
module tsr_field_slice #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          clr_flag,
  input  logic          wr,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] live,
  output logic [FW-1:0] snap,
  output logic          flag
);
  logic moved;
  assign moved = (live != snap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      flag <= 1'b0;
    end else if (cap) begin
      snap <= live;
      flag <= moved;
    end else begin
      if (clr_flag) flag <= 1'b0;
      if (wr) snap <= wdata;
    end
  end
endmodule

// File: rtl/tsr_cmd_decode.sv
module tsr_cmd_decode
  import tsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             locked,
  output logic             cap_ev,
  output logic             load_ev,
  output logic             load_q
);
  assign cap_ev  = cmd_en && (cmd_code == CMD_SNAPSHOT);
  assign load_ev = cmd_en && (cmd_code == CMD_LOAD_CLOCK) && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_ev;
  end
endmodule

// File: rtl/tod_snapshot_regs.sv
module tod_snapshot_regs
  import tsr_pkg::*;
#(
  parameter int FW       = 8,
  parameter int NF       = 8,
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 0,
  parameter int FLG_ADDR = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FW-1:0]    wdata,
  output logic [FW-1:0]    rdata,
  input  logic             cmd_en,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [NF*FW-1:0] live_time,
  input  logic             div_tap,
  output logic             load_en,
  output logic [NF*FW-1:0] load_time,
  output logic             test_fast,
  output logic             test_parallel,
  output logic             lock,
  output logic             freq_out
);
  localparam int BASE = FLG_ADDR + 1;

  logic [FW-1:0] ctrl_q;
  logic [NF-1:0] flag_q;
  logic [FW-1:0] snap_v [NF];
  logic          wr_ok;
  logic          ctrl_wr;
  logic          cap_ev;
  logic          load_ev;

  assign wr_ok   = wr_en && !cmd_en;
  assign ctrl_wr = wr_ok && (addr == ADDR_W'(CTL_ADDR));

  tsr_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_code(cmd_code),
    .locked(ctrl_q[CTL_LOCK]), .cap_ev(cap_ev), .load_ev(load_ev), .load_q(load_en)
  );

  for (genvar k = 0; k < NF; k++) begin : g_field
    logic sel;
    assign sel = wr_ok && (addr == ADDR_W'(BASE + k));
    tsr_field_slice #(.FW(FW)) u_slice (
      .clk(clk), .rst_n(rst_n), .cap(cap_ev), .clr_flag(load_ev), .wr(sel),
      .wdata(wdata), .live(live_time[k*FW +: FW]), .snap(snap_v[k]), .flag(flag_q[k])
    );
    assign load_time[k*FW +: FW] = snap_v[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTL_ADDR)) rdata = ctrl_q;
    if (addr == ADDR_W'(FLG_ADDR)) rdata = FW'(flag_q);
    for (int k = 0; k < NF; k++)
      if (addr == ADDR_W'(BASE + k)) rdata = snap_v[k];
  end

  assign test_fast     = ctrl_q[CTL_TEST0];
  assign test_parallel = ctrl_q[CTL_TEST1];
  assign lock          = ctrl_q[CTL_LOCK];
  assign freq_out      = ctrl_q[CTL_FREQ] && cs_n && div_tap;
endmodule

// File: rtl/tsr_checks.sv
module tsr_checks
  import tsr_pkg::*;
#(
  parameter int FW = 8,
  parameter int NF = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cmd_en,
  input logic [CMD_W-1:0] cmd_code,
  input logic [NF*FW-1:0] live_time,
  input logic             load_en,
  input logic [NF*FW-1:0] load_time,
  input logic [NF-1:0]    flag_q,
  input logic             lock,
  input logic             ctrl_wr,
  input logic             cap_ev,
  input logic             freq_out
);
  assert_snapshot_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> load_time == $past(live_time));

  for (genvar k = 0; k < NF; k++) begin : g_flag
    assert_flag_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> flag_q[k] == ($past(live_time[k*FW +: FW]) != $past(load_time[k*FW +: FW])));
  end

  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_code == CMD_LOAD_CLOCK && !lock) |=> (load_en && flag_q == '0));

  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en);

  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_code == CMD_LOAD_CLOCK && lock) |=> (!load_en && $stable(flag_q)));

  assert_freq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_out |-> cs_n);

  assert_lock_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(lock));
endmodule

bind tod_snapshot_regs tsr_checks #(.FW(FW), .NF(NF)) u_checks (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_en(cmd_en), .cmd_code(cmd_code),
  .live_time(live_time), .load_en(load_en), .load_time(load_time), .flag_q(flag_q),
  .lock(lock), .ctrl_wr(ctrl_wr), .cap_ev(cap_ev), .freq_out(freq_out)
);

// File: tb/tb_tod_snapshot_regs.sv
module tb_tod_snapshot_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cmd_en = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [63:0] live_time = '0;
  logic        div_tap = 1'b0;
  logic        load_en;
  logic [63:0] load_time;
  logic        test_fast, test_parallel, lock, freq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_snap [8];
  logic [7:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_snapshot_regs dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cmd_en(cmd_en), .cmd_code(cmd_code), .live_time(live_time),
    .div_tap(div_tap), .load_en(load_en), .load_time(load_time), .test_fast(test_fast),
    .test_parallel(test_parallel), .lock(lock), .freq_out(freq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic command(input logic [3:0] c);
    @(negedge clk); cmd_en = 1'b1; cmd_code = c;
    @(posedge clk); #1; cmd_en = 1'b0;
  endtask

  task automatic model_capture();
    for (int k = 0; k < 8; k++) begin
      m_flags[k] = (live_time[k*8 +: 8] != m_snap[k]);
      m_snap[k]  = live_time[k*8 +: 8];
    end
  endtask

  task automatic check_image(input string req);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      peek(4'(k + 2), v); chk(req, v, m_snap[k]);
    end
    peek(4'd1, v); chk(req, v, m_flags);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), v); chk("R1 reset byte", v, 8'h00);
    end
    chk("R1 reset outputs", {load_en, test_fast, test_parallel, lock, freq_out}, 5'b0);
  endtask

  task automatic t_rw();
    logic [7:0] v;
    host_write(4'd0, 8'h0C);
    peek(4'd0, v); chk("R2 ctrl readback", v, 8'h0C);
    chk("R2 test bits", {test_fast, test_parallel, lock}, 3'b110);
    host_write(4'd0, 8'h10);
    chk("R2 lock bit", {test_fast, test_parallel, lock}, 3'b001);
    host_write(4'd0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      m_snap[k] = 8'h30 + 8'(k);
      host_write(4'(k + 2), m_snap[k]);
    end
    check_image("R2 field readback");
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    host_write(4'd1, 8'hFF);
    peek(4'd1, v); chk("R3 flag byte write ignored", v, m_flags);
    host_write(4'd12, 8'hA5);
    peek(4'd12, v); chk("R3 high address reads zero", v, 8'h00);
    check_image("R3 no side effect");
  endtask

  task automatic t_capture();
    live_time = 64'h0807_2306_1514_1259;
    command(4'hF); model_capture();
    chk("R4 load_time after snapshot", load_time, live_time);
    check_image("R4/R5 first snapshot");
    command(4'hF); model_capture();
    check_image("R5 unchanged live gives zero flags");
    chk("R5 flags zero", m_flags, 8'h00);
    live_time[0 +: 8] = 8'h00; live_time[40 +: 8] = 8'h24;
    command(4'hF); model_capture();
    check_image("R5 partial change");
    chk("R5 expected pattern", m_flags, 8'h21);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    host_write(4'd0, 8'h10);
    command(4'hE);
    chk("R7 no load while locked", load_en, 1'b0);
    peek(4'd1, v); chk("R7 flags kept", v, m_flags);
    host_write(4'd0, 8'h00);
    host_write(4'd4, 8'h17);
    m_snap[2] = 8'h17;
    command(4'hE);
    m_flags = 8'h00;
    chk("R6 load strobe", load_en, 1'b1);
    chk("R6 load data", load_time, {m_snap[7], m_snap[6], m_snap[5], m_snap[4],
                                     m_snap[3], m_snap[2], m_snap[1], m_snap[0]});
    peek(4'd1, v); chk("R6 flags cleared", v, 8'h00);
    @(posedge clk); #1;
    chk("R6 strobe one cycle", load_en, 1'b0);
  endtask

  task automatic t_badcmd();
    live_time = 64'h1111_1111_1111_1111;
    command(4'h7);
    chk("R9 no load on other code", load_en, 1'b0);
    check_image("R9 image unchanged");
  endtask

  task automatic t_priority();
    @(negedge clk);
    cmd_en = 1'b1; cmd_code = 4'hF; wr_en = 1'b1; addr = 4'd3; wdata = 8'h55;
    @(posedge clk); #1; cmd_en = 1'b0; wr_en = 1'b0;
    model_capture();
    check_image("R10 write dropped during command");
    @(negedge clk);
    cmd_en = 1'b1; cmd_code = 4'h3; wr_en = 1'b1; addr = 4'd0; wdata = 8'h10;
    @(posedge clk); #1; cmd_en = 1'b0; wr_en = 1'b0;
    chk("R10 ctrl write dropped", lock, 1'b0);
  endtask

  task automatic t_freq();
    host_write(4'd0, 8'h01);
    cs_n = 1'b1; div_tap = 1'b1; #1;
    chk("R8 pass tap high", freq_out, 1'b1);
    div_tap = 1'b0; #1;
    chk("R8 pass tap low", freq_out, 1'b0);
    div_tap = 1'b1; cs_n = 1'b0; #1;
    chk("R8 selected blocks", freq_out, 1'b0);
    cs_n = 1'b1;
    host_write(4'd0, 8'h00);
    chk("R8 disabled blocks", freq_out, 1'b0);
    div_tap = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_snap[k] = 8'h00;
    m_flags = 8'h00;
    #(CLK_PERIOD*2 + 2);
    t_reset();
    rst_n = 1'b1;
    t_rw();
    t_ignored();
    t_capture();
    t_lock();
    t_badcmd();
    t_priority();
    t_freq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule